// File: doc/BRIEF.md
# Three-wire EEPROM shift engine

This block moves short bit strings between a processor register pair and a serial EEPROM over a three-line link. The link has a clock output, one shared bidirectional data line and a chip select. Software writes a data byte and then a command byte. The command byte holds a clock count of 0 to 8, a direction flag, a flag that releases the data line once the last clock has risen, and a flag that makes the engine wait for the EEPROM to report ready. The engine generates the serial clock by dividing the system clock, and shifts the bits in or out most significant bit first. While it works it shows a busy flag, and when busy drops it raises a one-cycle interrupt.

Chip select is a plain general-purpose output that software drives, so it is not part of this block. To run a longer EEPROM transaction, software raises chip select and then issues a series of commands of up to eight bits each. After a read, software issues a zero-count command with the release flag clear, so that the engine drives the data line again.

Top module: `ee3w_engine`

## Requirements
- R1: After reset the engine is idle: busy low, interrupt low, serial clock low, data line driven (output enable high), and the command and data registers read 0.
- R2: A write to the command register while idle starts a command and sets busy on the next clock. Command bits: 7 = wait-for-ready, 5 = release line, 4 = read, 3:0 = clock count. Exactly that many clock pulses are issued. A count above 8 is treated as 8 and reads back as 8.
- R3: The serial clock idles low. Each high phase and each low phase lasts CLK_HZ/(2*SCK_HZ) system cycles, which is 50 cycles for the defaults (500 kHz from 50 MHz).
- R4: In write mode the data line is driven, and bit 7 of the data register is presented while the clock is low. Each falling clock edge shifts the register left with zero fill, so the EEPROM sees the bits MSB first on the rising edges. After the command the register holds its original value shifted left by the count.
- R5: In read mode the data line is released during the clocks. The input is sampled at each rising clock edge, and the N sampled bits land MSB first in register bits N-1:0. Bits 7:N keep their old value.
- R6: A count of 0 issues no clock pulses. The only effect is that the output enable becomes the inverse of the release flag.
- R7: With the release flag set, the output enable drops one system cycle after the last rising clock edge and stays low. With it clear, the line is driven at the end of the command, even after a read.
- R8: Every falling edge of busy produces an interrupt pulse exactly one cycle wide.
- R9: With both wait-for-ready and release set, busy stays high after the last clock until a rising edge is seen on the data input. With release clear, wait-for-ready has no effect.
- R10: Writes to the command or data register while busy are ignored.
- R11: The command register reads back wait-for-ready in bit 7, busy in bit 6, release in bit 5, read in bit 4 and the clamped count in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Command register write strobe |
| ctrl_wdata_i | input | 8 | Command byte |
| data_we_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Data byte |
| ctrl_rdata_o | output | 8 | Command register readback including busy |
| data_rdata_o | output | 8 | Data register readback |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock to EEPROM |
| sd_o | output | 1 | Serial data out value |
| sd_oe_o | output | 1 | Serial data output enable (1 = driven) |
| sd_i | input | 1 | Serial data line as seen at the pad |

## Verification
The assertions check on every cycle that the clock stays low while idle and that the interrupt never lasts more than one cycle. They also check that the number of rising clock edges matches the latched count when busy falls, that a command write during busy leaves the latched command unchanged, and that the line is released after the last rising edge when requested. Only the bench's scenarios can show the data values: the bit order and zero fill of writes, the right-justified merge of reads that keeps the upper bits, and the exact phase lengths. The same goes for the wait-for-ready hold that ends on the EEPROM's rising edge, and for the line being driven again by a zero-count command.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic             wfr;
    logic             hiz;
    logic             rd;
    logic [CNT_W-1:0] cnt;
  } cmd_t;
endpackage

// File: rtl/ee3w_tick.sv
module ee3w_tick #(
  parameter int HALF = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee3w_sync.sv
module ee3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign q_o    = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ee3w_datareg.sv
module ee3w_datareg #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  load_val_i,
  input  logic          shl_i,
  input  logic          shin_i,
  input  logic          bit_i,
  input  logic [CW-1:0] len_i,
  output logic [W-1:0]  q_o
);
  logic [W:0]   mask_full;
  logic [W-1:0] mask;
  logic [W-1:0] q_q;

  // field of len_i low bits receives the incoming stream
  assign mask_full = ((W+1)'(1) << len_i) - (W+1)'(1);
  assign mask      = mask_full[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= load_val_i;
    else if (shl_i)  q_q <= {q_q[W-2:0], 1'b0};
    else if (shin_i) q_q <= (q_q & ~mask) | ({q_q[W-2:0], bit_i} & mask);
  end

  assign q_o = q_q;
endmodule

// File: rtl/ee3w_seq.sv
module ee3w_seq
  import ee3w_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  cmd_t cmd_i,
  input  logic tick_i,
  input  logic sd_rise_i,
  output cmd_t cmd_o,
  output logic busy_o,
  output logic sck_o,
  output logic oe_o,
  output logic shl_o,
  output logic shin_o,
  output logic run_o
);
  seq_state_e       state_q;
  cmd_t             cmd_q;
  logic [CNT_W-1:0] bits_q;
  logic             sck_q, oe_q, busy_q;
  logic [CNT_W-1:0] cnt_clamped;
  logic             last_bit;

  assign cnt_clamped = (cmd_i.cnt > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : cmd_i.cnt;
  assign last_bit    = (bits_q == cmd_q.cnt);

  assign run_o  = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign shin_o = (state_q == ST_LOW)  && tick_i &&  cmd_q.rd;
  assign shl_o  = (state_q == ST_HIGH) && tick_i && !cmd_q.rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      bits_q  <= '0;
      sck_q   <= 1'b0;
      oe_q    <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cmd_q     <= cmd_i;
          cmd_q.cnt <= cnt_clamped;
          bits_q    <= '0;
          busy_q    <= 1'b1;
          if (cnt_clamped == '0) begin
            oe_q    <= ~cmd_i.hiz;
            state_q <= (cmd_i.wfr && cmd_i.hiz) ? ST_WAIT : ST_FIN;
          end else begin
            oe_q    <= ~cmd_i.rd;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: if (tick_i) begin
          sck_q   <= 1'b1;
          bits_q  <= bits_q + 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          // release one cycle after the final rising edge
          if (last_bit && cmd_q.hiz) oe_q <= 1'b0;
          if (tick_i) begin
            sck_q <= 1'b0;
            if (last_bit) begin
              oe_q    <= ~cmd_q.hiz;
              state_q <= (cmd_q.wfr && cmd_q.hiz) ? ST_WAIT : ST_FIN;
            end else begin
              state_q <= ST_LOW;
            end
          end
        end
        ST_WAIT: if (sd_rise_i) state_q <= ST_FIN;
        ST_FIN: begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign oe_o   = oe_q;

  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);

  assert_hiz_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && last_bit && cmd_q.hiz) |=> !oe_q);

  assert_wfr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !sd_rise_i) |=> busy_q);

  assert_write_driven_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sck_q) && !cmd_q.rd) |-> $past(oe_q));
endmodule

// File: rtl/ee3w_engine.sv
module ee3w_engine
  import ee3w_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SCK_HZ   = 500_000,
  parameter int MAX_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] ctrl_rdata_o,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  localparam int HALF = (CLK_HZ / (2 * SCK_HZ) > 0) ? CLK_HZ / (2 * SCK_HZ) : 1;

  cmd_t              cmd_in, cmd_cur;
  logic              busy, start, tick, run, shl, shin;
  logic              sd_sync, sd_rise, busy_prev_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_in.wfr = ctrl_wdata_i[7];
  assign cmd_in.hiz = ctrl_wdata_i[5];
  assign cmd_in.rd  = ctrl_wdata_i[4];
  assign cmd_in.cnt = ctrl_wdata_i[3:0];
  assign start      = ctrl_we_i & ~busy;

  ee3w_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  ee3w_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sd_i),
    .q_o   (sd_sync),
    .rise_o(sd_rise)
  );

  ee3w_seq #(.MAX_BITS(MAX_BITS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cmd_i    (cmd_in),
    .tick_i   (tick),
    .sd_rise_i(sd_rise),
    .cmd_o    (cmd_cur),
    .busy_o   (busy),
    .sck_o    (sck_o),
    .oe_o     (sd_oe_o),
    .shl_o    (shl),
    .shin_o   (shin),
    .run_o    (run)
  );

  ee3w_datareg #(.W(DATA_W), .CW(CNT_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (data_we_i & ~busy),
    .load_val_i(data_wdata_i),
    .shl_i     (shl),
    .shin_i    (shin),
    .bit_i     (sd_sync),
    .len_i     (cmd_cur.cnt),
    .q_o       (data_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_prev_q <= 1'b0;
    else         busy_prev_q <= busy;
  end

  assign irq_o        = busy_prev_q & ~busy;
  assign busy_o       = busy;
  assign sd_o         = data_q[DATA_W-1];
  assign data_rdata_o = data_q;
  assign ctrl_rdata_o = {cmd_cur.wfr, busy, cmd_cur.hiz, cmd_cur.rd, cmd_cur.cnt};

  // checker: rising serial clock edges per command
  logic             sck_prev_q;
  logic [CNT_W:0]   pulse_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q  <= 1'b0;
      pulse_cnt_q <= '0;
    end else begin
      sck_prev_q <= sck_o;
      if (start)                    pulse_cnt_q <= '0;
      else if (sck_o && !sck_prev_q) pulse_cnt_q <= pulse_cnt_q + 1'b1;
    end
  end

  assert_pulse_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (pulse_cnt_q == {1'b0, cmd_cur.cnt}));

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_cmd_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_we_i) |=> $stable(ctrl_rdata_o[5:0] & 6'h3F) || !$past(busy));

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_cur.cnt <= CNT_W'(MAX_BITS));
endmodule

// File: tb/sim_ee3w_engine.sv
module sim_ee3w_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0, data_we = 1'b0;
  logic [7:0] ctrl_wd = '0, data_wd = '0;
  logic [7:0] ctrl_rd, data_rd;
  logic       busy, irq, sck, sd_o, sd_oe;
  logic       sd_i = 1'b0;

  int n_chk = 0, n_err = 0;
  int pulses, hi_cyc, irq_cnt, wr_bad, rd_bad;
  logic [7:0] cap, rd_sr;
  logic       rd_mode = 1'b0, sck_seen = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  ee3w_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .data_we_i(data_we), .data_wdata_i(data_wd),
    .ctrl_rdata_o(ctrl_rd), .data_rdata_o(data_rd),
    .busy_o(busy), .irq_o(irq), .sck_o(sck),
    .sd_o(sd_o), .sd_oe_o(sd_oe), .sd_i(sd_i)
  );

  // EEPROM model and line monitor, sampled between edges
  always @(negedge clk) begin
    if (sck && !sck_seen) begin
      pulses++;
      if (rd_mode) begin
        if (sd_oe) rd_bad++;
      end else begin
        if (!sd_oe) wr_bad++;
        cap = {cap[6:0], sd_o};
      end
    end
    if (!sck && sck_seen) begin
      rd_sr = {rd_sr[6:0], 1'b0};
      sd_i  = rd_sr[7];
    end
    sck_seen = sck;
  end

  always @(posedge clk) begin
    if (sck) hi_cyc++;
    if (irq) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); data_we = 1'b1; data_wd = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic start_cmd(input logic [7:0] c, input logic [7:0] rbits);
    pulses = 0; hi_cyc = 0; irq_cnt = 0; wr_bad = 0; rd_bad = 0; cap = '0;
    rd_mode = c[4]; rd_sr = rbits; sd_i = rbits[7];
    @(negedge clk); ctrl_we = 1'b1; ctrl_wd = c;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 sck", sck, 0);
    chk("R1 oe", sd_oe, 1);
    chk("R1 irq", irq, 0);
    chk("R1 ctrl", ctrl_rd, 8'h00);
    chk("R1 data", data_rd, 8'h00);
  endtask

  task automatic t_write8();
    wr_data(8'hC3);
    start_cmd(8'h08, 8'h00);
    chk("R2 busy set", busy, 1);
    chk("R11 busy bit", ctrl_rd[6], 1);
    wait_idle();
    chk("R4 bits out", cap, 8'hC3);
    chk("R4 driven", wr_bad, 0);
    chk("R4 shifted", data_rd, 8'h00);
    chk("R2 pulses", pulses, 8);
    chk("R3 high cycles", hi_cyc, 8 * 50);
    chk("R7 still driven", sd_oe, 1);
    chk("R8 irq pulses", irq_cnt, 1);
  endtask

  task automatic t_write6_hiz();
    wr_data(8'hB4);
    start_cmd(8'h26, 8'h00);
    wait_idle();
    chk("R4 six bits", cap, 8'h2D);
    chk("R4 shifted by six", data_rd, 8'h00);
    chk("R2 pulses six", pulses, 6);
    chk("R7 released", sd_oe, 0);
    chk("R11 readback", ctrl_rd, 8'h26);
  endtask

  task automatic t_zero();
    start_cmd(8'h20, 8'h00);
    wait_idle();
    chk("R6 zero hiz pulses", pulses, 0);
    chk("R6 zero hiz oe", sd_oe, 0);
    start_cmd(8'h00, 8'h00);
    wait_idle();
    chk("R6 zero pulses", pulses, 0);
    chk("R6 retake drive", sd_oe, 1);
    chk("R8 zero irq", irq_cnt, 1);
  endtask

  task automatic t_read();
    wr_data(8'hA5);
    start_cmd(8'h15, 8'hB0);
    wait_idle();
    chk("R5 merge five", data_rd, 8'hB6);
    chk("R5 line released", rd_bad, 0);
    chk("R7 driven after read", sd_oe, 1);
    wr_data(8'h00);
    start_cmd(8'h18, 8'h3C);
    wait_idle();
    chk("R5 read eight", data_rd, 8'h3C);
    chk("R2 read pulses", pulses, 8);
  endtask

  task automatic t_clamp();
    wr_data(8'hFF);
    start_cmd(8'h0C, 8'h00);
    wait_idle();
    chk("R2 clamp pulses", pulses, 8);
    chk("R2 clamp readback", ctrl_rd[3:0], 8);
  endtask

  task automatic t_busy_ignore();
    wr_data(8'h81);
    start_cmd(8'h08, 8'h00);
    repeat (20) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wd = 8'h23;
    data_we = 1'b1; data_wd = 8'h55;
    @(negedge clk);
    ctrl_we = 1'b0; data_we = 1'b0;
    wait_idle();
    chk("R10 pulses kept", pulses, 8);
    chk("R10 data kept", cap, 8'h81);
    chk("R10 data not loaded", data_rd, 8'h00);
    chk("R10 cmd kept", ctrl_rd, 8'h08);
  endtask

  task automatic t_wfr();
    wr_data(8'h5A);
    start_cmd(8'hA8, 8'h00);
    repeat (1200) @(negedge clk);
    chk("R9 held busy", busy, 1);
    chk("R9 no irq yet", irq_cnt, 0);
    chk("R9 line released", sd_oe, 0);
    sd_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 busy released", busy, 0);
    chk("R8 irq after ready", irq_cnt, 1);
    start_cmd(8'h88, 8'h00);
    wait_idle();
    chk("R9 ignored without hiz", busy, 0);
    chk("R9 pulses", pulses, 8);
    chk("R7 driven", sd_oe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write8();
    t_write6_hiz();
    t_zero();
    t_read();
    t_clamp();
    t_busy_ignore();
    t_wfr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule